// File: doc/BRIEF.md
# Indexed Interrupt Routing Table Register Window

This block is the software-facing register file of an interrupt router. Software reaches a set of internal 32-bit registers through two bus locations: an index register that names the internal register, and a data window through which the named register is read or written. The internal registers are an identifier register, a read-only version register, and a table of 64-bit routing entries. Each entry occupies two consecutive indices: the even one holds bits 31:0 and the odd one holds bits 63:32.

Writes to an entry half replace only that half. Two status bits in every entry belong to the delivery logic. A bus write cannot change them, and the delivery logic sets them through a status port. An entry in edge mode never keeps its remote-request bit set. The delivery logic reads whole entries through a separate read port.

Top module: `irq_redir_regfile`

## Requirements
- R1: After synchronous reset the index register reads 0, the identifier field is 0, and every entry holds 0x0000_0000_0001_0000 (only mask bit 16 set).
- R2: Bus offset 0x00 is the index register, which reads back its 8 bits zero-extended. Offset 0x10 is the data window. Any other offset reads 0 and ignores writes.
- R3: Index 0 is the identifier register: a write keeps wdata[27:24], and a read returns that field in bits 27:24 with all other bits 0.
- R4: Index 1 reads the constant 0x0017_0011: version code 0x11 in bits 7:0 and entry count minus one (23) in bits 23:16. Writes to it have no effect.
- R5: Index 0x10+2n reaches bits 31:0 of entry n, and index 0x11+2n reaches bits 63:32, for n from 0 to 23.
- R6: A window write to an entry half replaces that half and leaves the other half unchanged.
- R7: Bit 12 (delivery status) and bit 14 (remote request) keep their previous values on every bus write. A status-port strobe sets bit 12 to the given value, and sets bit 14 to the given value ANDed with trigger bit 15.
- R8: After a bus write to an entry, if bit 15 (trigger mode, 0 = edge) is 0, bit 14 is 0.
- R9: Indices 2 to 0x0F and 0x40 and above read 0 through the window and ignore writes.
- R10: The side read port returns the full 64-bit entry one cycle after the index is presented. Indices 24 and above return 0.
- R11: Bus read data is registered. It shows the addressed value in the cycle after bus_rd and is 0 after a cycle without bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| st_we | input | 1 | Status update strobe from delivery logic |
| st_idx | input | 5 | Entry number for status update |
| st_dlv | input | 1 | New delivery-status bit value |
| st_rirr | input | 1 | New remote-request bit value (level mode only) |
| tbl_rd_idx | input | 5 | Side read entry number |
| tbl_entry | output | 64 | Registered side read entry |

## Verification
The window is tested with directed sequences that reach the identifier register, the version register, both halves of the first and last entries, and the indices just outside the table on each side. These sequences separate an off-by-one in the entry mapping from a swap of the two halves. Status-port updates are followed by bus writes of both halves with all ones and all zeros, which shows whether the protected bits really resist bus writes and whether the edge-mode clear acts. A seeded random mix of index values, offsets, data and status updates runs against a bench model. The side port then scans the whole table, so a write that landed on the wrong entry shows up even when no window read went there.

// File: rtl/irr_pkg.sv
`timescale 1ns/1ps
package irr_pkg;
  localparam int DATA_W   = 32;
  localparam int ENT_W    = 64;
  localparam int BIT_DLV  = 12;
  localparam int BIT_RIRR = 14;
  localparam int BIT_TRIG = 15;
  localparam int BIT_MASK = 16;
  localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << BIT_MASK;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ID   = 2'd1,
    ACC_VER  = 2'd2,
    ACC_ENT  = 2'd3
  } acc_kind_t;
endpackage

// File: rtl/irr_win_decode.sv
`timescale 1ns/1ps
module irr_win_decode
  import irr_pkg::*;
#(
  parameter int NUM_ENT  = 24,
  parameter int TBL_BASE = 16,
  parameter int IDX_W    = $clog2(NUM_ENT)
) (
  input  logic [7:0]       sel,
  output acc_kind_t        kind,
  output logic [IDX_W-1:0] ent_idx,
  output logic             ent_hi
);
  logic [7:0] offs;
  logic [6:0] ent_num;

  always_comb begin
    offs    = sel - 8'(TBL_BASE);
    ent_num = 7'(offs >> 1);
    ent_idx = ent_num[IDX_W-1:0];
    ent_hi  = sel[0];
    if (sel == 8'd0)
      kind = ACC_ID;
    else if (sel == 8'd1)
      kind = ACC_VER;
    else if ((sel >= 8'(TBL_BASE)) && (int'(ent_num) < NUM_ENT))
      kind = ACC_ENT;
    else
      kind = ACC_NONE;
  end
endmodule

// File: rtl/irr_entry_merge.sv
`timescale 1ns/1ps
module irr_entry_merge
  import irr_pkg::*;
(
  input  logic [ENT_W-1:0]  cur,
  input  logic              st_hit,
  input  logic              st_dlv,
  input  logic              st_rirr,
  input  logic              wr_hit,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ENT_W-1:0]  nxt
);
  logic [ENT_W-1:0] base;
  logic [ENT_W-1:0] cand;

  always_comb begin
    base = cur;
    if (st_hit) begin
      base[BIT_DLV]  = st_dlv;
      base[BIT_RIRR] = st_rirr & cur[BIT_TRIG];
    end
    cand = wr_hi ? {wr_data, base[DATA_W-1:0]} : {base[ENT_W-1:DATA_W], wr_data};
    cand[BIT_DLV]  = base[BIT_DLV];
    cand[BIT_RIRR] = base[BIT_RIRR];
    if (!cand[BIT_TRIG])
      cand[BIT_RIRR] = 1'b0;
    nxt = wr_hit ? cand : base;
  end
endmodule

// File: rtl/irr_entry_bank.sv
`timescale 1ns/1ps
module irr_entry_bank
  import irr_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic              st_dlv,
  input  logic              st_rirr,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [ENT_W-1:0]  a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [ENT_W-1:0]  b_data
);
  logic [ENT_W-1:0] ent_q [NUM_ENT];
  logic [ENT_W-1:0] ent_d [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    irr_entry_merge u_merge (
      .cur     (ent_q[g]),
      .st_hit  (st_we && (st_idx == IDX_W'(g))),
      .st_dlv  (st_dlv),
      .st_rirr (st_rirr),
      .wr_hit  (wr_en && (wr_idx == IDX_W'(g))),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .nxt     (ent_d[g])
    );
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (rst) ent_q[i] <= ENT_RST;
      else     ent_q[i] <= ent_d[i];
    end
  end

  always_comb begin
    a_data = '0;
    b_data = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (a_idx == IDX_W'(i)) a_data = ent_q[i];
      if (b_idx == IDX_W'(i)) b_data = ent_q[i];
    end
  end
endmodule

// File: rtl/irq_redir_regfile.sv
`timescale 1ns/1ps
module irq_redir_regfile
  import irr_pkg::*;
#(
  parameter int          NUM_ENT  = 24,
  parameter int          TBL_BASE = 16,
  parameter logic [7:0]  SEL_OFF  = 8'h00,
  parameter logic [7:0]  WIN_OFF  = 8'h10,
  parameter logic [7:0]  VER_CODE = 8'h11,
  parameter int          IDX_W    = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic              st_dlv,
  input  logic              st_rirr,
  input  logic [IDX_W-1:0]  tbl_rd_idx,
  output logic [63:0]       tbl_entry
);
  localparam logic [31:0] VER_VAL = {8'd0, 8'(NUM_ENT - 1), 8'd0, VER_CODE};

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  acc_kind_t        kind;
  logic [IDX_W-1:0] ent_idx;
  logic             ent_hi;
  logic [63:0]      ent_rd;
  logic [63:0]      side_rd;
  logic             hit_sel, hit_win;
  logic [31:0]      rd_val;

  assign hit_sel = (bus_addr == SEL_OFF);
  assign hit_win = (bus_addr == WIN_OFF);

  irr_win_decode #(.NUM_ENT(NUM_ENT), .TBL_BASE(TBL_BASE), .IDX_W(IDX_W)) u_dec (
    .sel     (sel_q),
    .kind    (kind),
    .ent_idx (ent_idx),
    .ent_hi  (ent_hi)
  );

  irr_entry_bank #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr && hit_win && (kind == ACC_ENT)),
    .wr_idx  (ent_idx),
    .wr_hi   (ent_hi),
    .wr_data (bus_wdata),
    .st_we   (st_we),
    .st_idx  (st_idx),
    .st_dlv  (st_dlv),
    .st_rirr (st_rirr),
    .a_idx   (ent_idx),
    .a_data  (ent_rd),
    .b_idx   (tbl_rd_idx),
    .b_data  (side_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else if (bus_wr) begin
      if (hit_sel)
        sel_q <= bus_wdata[7:0];
      if (hit_win && (kind == ACC_ID))
        id_q <= bus_wdata[27:24];
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_sel) begin
      rd_val = {24'd0, sel_q};
    end else if (hit_win) begin
      unique case (kind)
        ACC_ID:  rd_val = {4'd0, id_q, 24'd0};
        ACC_VER: rd_val = VER_VAL;
        ACC_ENT: rd_val = ent_hi ? ent_rd[63:32] : ent_rd[31:0];
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tbl_entry <= '0;
    end else begin
      bus_rdata <= bus_rd ? rd_val : '0;
      tbl_entry <= side_rd;
    end
  end
endmodule

// File: rtl/irr_regfile_chk.sv
`timescale 1ns/1ps
module irr_regfile_chk #(
  parameter int         NUM_ENT  = 24,
  parameter logic [7:0] WIN_OFF  = 8'h10,
  parameter logic [7:0] VER_CODE = 8'h11,
  parameter int         IDX_W    = $clog2(NUM_ENT)
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic [7:0]       bus_addr,
  input logic [7:0]       sel_q,
  input logic [31:0]      bus_rdata,
  input logic [IDX_W-1:0] tbl_rd_idx,
  input logic [63:0]      tbl_entry
);
  a_r1_reset_clears_outputs: assert property (@(posedge clk)
    rst |=> (bus_rdata == 32'd0 && tbl_entry == 64'd0));

  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 32'd0);

  a_r4_version_value: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == WIN_OFF && sel_q == 8'd1)
      |=> bus_rdata == {8'd0, 8'(NUM_ENT - 1), 8'd0, VER_CODE});

  a_r10_side_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (int'(tbl_rd_idx) >= NUM_ENT) |=> tbl_entry == 64'd0);

  a_r8_edge_no_remote: assert property (@(posedge clk) disable iff (rst)
    !tbl_entry[15] |-> !tbl_entry[14]);
endmodule

bind irq_redir_regfile irr_regfile_chk #(
  .NUM_ENT(NUM_ENT), .WIN_OFF(WIN_OFF), .VER_CODE(VER_CODE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr), .sel_q(sel_q),
  .bus_rdata(bus_rdata), .tbl_rd_idx(tbl_rd_idx), .tbl_entry(tbl_entry)
);

// File: tb/test_irq_redir_regfile.sv
`timescale 1ns/1ps
module test_irq_redir_regfile;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        st_we = 0, st_dlv = 0, st_rirr = 0;
  logic [4:0]  st_idx = 0, tbl_rd_idx = 0;
  logic [63:0] tbl_entry;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic [63:0] m_tbl [N];

  always #2.5 clk = ~clk;

  irq_redir_regfile i_irq_redir_regfile (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .st_we(st_we), .st_idx(st_idx),
    .st_dlv(st_dlv), .st_rirr(st_rirr), .tbl_rd_idx(tbl_rd_idx), .tbl_entry(tbl_entry)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int e;
    if (a == 8'h00) return {24'd0, m_sel};
    if (a != 8'h10) return 32'd0;
    if (m_sel == 8'd0) return {4'd0, m_id, 24'd0};
    if (m_sel == 8'd1) return 32'h0017_0011;
    if (m_sel >= 8'h10 && m_sel < 8'h40) begin
      e = (int'(m_sel) - 16) / 2;
      return m_sel[0] ? m_tbl[e][63:32] : m_tbl[e][31:0];
    end
    return 32'd0;
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    logic [63:0] o, n;
    int e;
    if (a == 8'h00) m_sel = d[7:0];
    else if (a == 8'h10) begin
      if (m_sel == 8'd0) m_id = d[27:24];
      else if (m_sel >= 8'h10 && m_sel < 8'h40) begin
        e = (int'(m_sel) - 16) / 2;
        o = m_tbl[e];
        n = m_sel[0] ? {d, o[31:0]} : {o[63:32], d};
        n[12] = o[12];
        n[14] = o[14];
        if (!n[15]) n[14] = 1'b0;
        m_tbl[e] = n;
      end
    end
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); model_write(a, d);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, input string tag);
    logic [31:0] e;
    e = exp_read(a);
    bus_rd = 1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
    check(tag, {32'd0, bus_rdata}, {32'd0, e});
  endtask

  task automatic stat_set(input int e, input logic dlv, input logic rirr);
    st_we = 1; st_idx = 5'(e); st_dlv = dlv; st_rirr = rirr;
    @(posedge clk);
    if (e < N) begin
      m_tbl[e][14] = rirr & m_tbl[e][15];
      m_tbl[e][12] = dlv;
    end
    @(negedge clk); st_we = 0;
  endtask

  task automatic side_check(input int e, input string tag);
    tbl_rd_idx = 5'(e);
    @(posedge clk); @(negedge clk);
    check(tag, tbl_entry, (e < N) ? m_tbl[e] : 64'd0);
  endtask

  task automatic scan_all(input string tag);
    for (int e = 0; e < 32; e++) side_check(e, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_sel = 0; m_id = 0;
    for (int e = 0; e < N; e++) m_tbl[e] = 64'h1_0000;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11 idle rdata zero", {32'd0, bus_rdata}, 64'd0);

    // R1 reset state
    bus_read(8'h00, "R1 index reset");
    bus_read(8'h10, "R1 id reset");
    bus_write(8'h00, 32'h10);
    bus_read(8'h10, "R1 entry0 low reset");
    side_check(5, "R1 entry5 reset via side");

    // R3 identifier
    bus_write(8'h00, 32'h0);
    bus_write(8'h10, 32'hFAFF_FFFF);
    bus_read(8'h10, "R3 id field");
    // R4 version, write ignored
    bus_write(8'h00, 32'h1);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, "R4 version");
    // R2 unknown offset
    bus_write(8'h04, 32'h0000_0033);
    bus_read(8'h04, "R2 other offset reads zero");
    bus_read(8'h00, "R2 index unchanged by other offset");
    // R5/R6 first and last entries, both halves
    bus_write(8'h00, 32'h11);
    bus_write(8'h10, 32'hDEAD_BEEF);
    bus_write(8'h00, 32'h10);
    bus_write(8'h10, 32'h0000_A0C5);
    bus_read(8'h10, "R5 entry0 low");
    side_check(0, "R6 entry0 both halves");
    bus_write(8'h00, 32'h3F);
    bus_write(8'h10, 32'h1234_5678);
    bus_read(8'h10, "R5 entry23 high");
    side_check(23, "R6 entry23 low untouched");
    // R7 protected bits, R8 edge clear
    bus_write(8'h00, 32'h12);
    bus_write(8'h10, 32'h0000_8000);
    stat_set(1, 1'b1, 1'b1);
    side_check(1, "R7 status port sets bits");
    bus_write(8'h10, 32'hFFFF_AFFF);
    side_check(1, "R7 protected bits survive write");
    bus_write(8'h10, 32'h0000_0000);
    side_check(1, "R8 edge write clears remote");
    stat_set(1, 1'b0, 1'b1);
    side_check(1, "R7 remote not set in edge mode");
    // R9 out-of-range indices
    bus_write(8'h00, 32'h05);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, "R9 index 5 reads zero");
    bus_write(8'h00, 32'h40);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, "R9 index 0x40 reads zero");
    scan_all("R9 table untouched / R10 side port");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [7:0] s;
      op = int'($urandom % 6);
      case (op)
        0: begin
          case ($urandom % 6)
            0: s = 8'h00;
            1: s = 8'h01;
            2: s = 8'($urandom % 16);
            3: s = 8'h40 + 8'($urandom % 192);
            default: s = 8'h10 + 8'($urandom % 48);
          endcase
          bus_write(8'h00, {24'($urandom), s});
        end
        1, 2: bus_write(($urandom % 8 == 0) ? 8'h08 : 8'h10, $urandom);
        3: bus_read(($urandom % 8 == 0) ? 8'h00 : 8'h10, "R5 R6 random window read");
        4: stat_set(int'($urandom % 26), 1'($urandom), 1'($urandom));
        default: side_check(int'($urandom % 32), "R10 random side read");
      endcase
    end
    scan_all("R7 R8 final table scan");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule